// File: doc/BRIEF.md
# Single-Buffer Serial Port Status Controller

This block is the register front end of a one-character serial port. A processor reaches it over a byte-wide bus with separate read and write strobes. Through that bus it programs a line-mode register, a bit-rate register and a control register, hands over one character for transmission, and collects one received character. A byte-wide status register reports whether the transmit holding register is free (transmit-empty) and whether the line has gone idle (transmit-end). It also reports whether a received character is waiting (receive-full) and whether a character was lost (overrun). The serial shifter and any interrupt logic sit outside the block. Characters go out to the shifter on a one-cycle parallel strobe and come in on a one-cycle parallel strobe.

Software clears status flags with a read-then-write-zero protocol. The block remembers which flags were seen as one in a status read. A later write of zero clears only those flags. Flags that were never seen survive the write, and a write can never raise a flag. To send, software writes the character and then clears transmit-empty. The block passes the byte to the shifter once the shifter is ready, and then raises transmit-empty and transmit-end again.

Top module: `sbuf_serial_ctl`

## Requirements
- R1: After reset the status register reads 0x84 (bit 7 transmit-empty, bit 2 transmit-end), the mode, rate, control and transmit-data registers read 0, and txValid is low.
- R2: Offsets are 0 mode, 1 bit rate, 2 control, 3 transmit data, 4 status and 5 receive data. The first four read back the last value written. Offsets 6 and 7 read 0 and ignore writes. Read data appears on busRdData in the cycle after the read strobe and holds until the next read.
- R3: On a status write, each of bits 7..3 (7 transmit-empty, 6 receive-full, 5 overrun, 4 and 3 unused) becomes 0 only if it is written 0 and its bit is set in the read-seen mask. A status write never sets any of these bits. Bits 4, 3 and 1 always read 0.
- R4: On a status write, bit 0 takes the written bit 0 directly, with no clear rule.
- R5: A status read ORs the returned value into the read-seen mask. A status write ANDs the mask with the written value, so writing zero to a flag that was not read first leaves the flag set.
- R6: While control bit 5 (transmit enable) is 0, a status write treats bits 7 and 2 as written one, so transmit-empty and transmit-end read 1 afterwards.
- R7: A write to the transmit-data register clears transmit-end. Transmit-end clears whenever transmit-empty becomes 0, and transmit-end is never 1 while transmit-empty is 0.
- R8: While transmit-empty is 0 and shifterReady is high, the next clock edge pulses txValid for one cycle with the pending byte on txByte and sets transmit-empty and transmit-end. While shifterReady is low, the byte is held and transmit-empty stays 0.
- R9: When control bit 4 (receive enable) is 1, an arriving character is stored and receive-full is set, unless receive-full is already set. In that case overrun is set and the character is dropped. When receive enable is 0, arrivals are ignored.
- R10: Reading the receive-data register clears receive-full.
- R11: A control write with bit 4 equal to 0 sets transmit-empty. A byte still waiting for the shifter is abandoned and never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busRdData | output | 8 | Read data, valid the cycle after busRdEn |
| shifterReady | input | 1 | Shifter can accept a character |
| txValid | output | 1 | One-cycle strobe handing txByte to the shifter |
| txByte | output | 8 | Character being handed to the shifter |
| rxValid | input | 1 | One-cycle strobe of an arriving character |
| rxByte | input | 8 | Arriving character |

## Verification
A wrong read-seen mask does not show up on a status read. It shows up at the next status write, when a flag is kept that should have cleared or cleared that should have been kept, and the following read reveals it. A wrong transmit-empty shows up one cycle later: txValid either fails to pulse after the flag is cleared, or pulses when it should not, and the following status read returns 0x84 where the transient value was expected. A wrong receive-full shows up on the second arrival, as a stored character where a dropped one was due (or the reverse) and a changed overrun bit.

// File: rtl/sbuf_pkg.sv
`timescale 1ns/1ps
package sbuf_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CFG_N  = 3;              // mode, rate, control at offsets 0..2
  localparam int CFG_IDX_W = $clog2(CFG_N);

  localparam logic [ADDR_W-1:0] OFF_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_RATE = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_TXD  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_RXD  = 3'd5;

  // status bit positions (software decodes these)
  localparam int ST_TXE = 7;
  localparam int ST_RXF = 6;
  localparam int ST_OVR = 5;
  localparam int ST_END = 2;
  localparam int ST_SW  = 0;

  // control bit positions
  localparam int CT_TXEN = 5;
  localparam int CT_RXEN = 4;

  localparam logic [DATA_W-1:0] STAT_RESET = 8'h84;
  localparam logic [DATA_W-1:0] RULE_MASK  = 8'hF8;  // bits under clear rule
  localparam logic [DATA_W-1:0] TX_FORCE   = 8'h84;  // forced when tx off

  typedef struct packed {
    logic [CFG_N-1:0]  wrCfg;
    logic              wrTxd;
    logic              wrStat;
    logic              rdStat;
    logic              rdRxd;
    logic              rdEn;
    logic [ADDR_W-1:0] rdSel;
  } busStrobe_t;
endpackage

// File: rtl/sbuf_bus_decode.sv
`timescale 1ns/1ps
module sbuf_bus_decode
  import sbuf_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStrobe_t        strobe
);
  logic [CFG_N-1:0] wrCfgVec;

  // one write strobe per configuration register
  for (genvar g = 0; g < CFG_N; g++) begin : gCfgDec
    assign wrCfgVec[g] = busWrEn && (busAddr == ADDR_W'(g));
  end

  always_comb begin
    strobe.wrCfg  = wrCfgVec;
    strobe.wrTxd  = busWrEn && (busAddr == OFF_TXD);
    strobe.wrStat = busWrEn && (busAddr == OFF_STAT);
    strobe.rdStat = busRdEn && (busAddr == OFF_STAT);
    strobe.rdRxd  = busRdEn && (busAddr == OFF_RXD);
    strobe.rdEn   = busRdEn;
    strobe.rdSel  = busAddr;
  end
endmodule

// File: rtl/sbuf_status_unit.sv
`timescale 1ns/1ps
module sbuf_status_unit
  import sbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txEn,
  input  logic              rxEn,
  input  logic              shifterReady,
  input  logic              rxValid,
  output logic [DATA_W-1:0] status,
  output logic              sendNow,
  output logic              rxStore
);
  logic [DATA_W-1:0] statQ, statD;
  logic [DATA_W-1:0] seenQ, seenD;
  logic [DATA_W-1:0] effWr;
  logic [DATA_W-1:0] ruled;
  logic              rxFullEff;
  logic              rxOver;

  always_comb begin
    // transmitter off: transmit-empty and transmit-end read as written one
    effWr = txEn ? wrData : (wrData | TX_FORCE);
    ruled = ((statQ & ~seenQ) | (statQ & seenQ & effWr)) & RULE_MASK;

    sendNow   = !statQ[ST_TXE] && shifterReady;
    rxFullEff = statQ[ST_RXF] && !strobe.rdRxd;
    rxStore   = rxValid && rxEn && !rxFullEff;
    rxOver    = rxValid && rxEn && rxFullEff;

    statD = statQ;
    if (strobe.wrStat) begin
      statD          = ruled;
      statD[ST_END]  = txEn ? statQ[ST_END] : 1'b1;
      statD[ST_SW]   = effWr[ST_SW];
    end
    if (strobe.wrTxd)  statD[ST_END] = 1'b0;
    if (strobe.rdRxd)  statD[ST_RXF] = 1'b0;
    if (!statD[ST_TXE]) statD[ST_END] = 1'b0;

    // hardware set events take precedence over software clears
    if (sendNow) begin
      statD[ST_TXE] = 1'b1;
      statD[ST_END] = 1'b1;
    end
    if (rxStore) statD[ST_RXF] = 1'b1;
    if (rxOver)  statD[ST_OVR] = 1'b1;
    if (strobe.wrCfg[OFF_CTRL] && !wrData[CT_RXEN]) statD[ST_TXE] = 1'b1;

    seenD = seenQ;
    if (strobe.wrStat) seenD = seenD & effWr;
    if (strobe.rdStat) seenD = seenD | statQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= STAT_RESET;
      seenQ <= '0;
    end else begin
      statQ <= statD;
      seenQ <= seenD;
    end
  end

  assign status = statQ;

  a_r7_end_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    statQ[ST_END] |-> statQ[ST_TXE]);

  a_r8_send_restores_flags: assert property (@(posedge clk) disable iff (!rstN)
    (!statQ[ST_TXE] && shifterReady) |=> (statQ[ST_TXE] && statQ[ST_END]));

  a_r9_overrun_on_full: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxEn && statQ[ST_RXF] && !strobe.rdRxd) |=> statQ[ST_OVR]);

  a_r10_read_clears_full: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdRxd && !(rxValid && rxEn)) |=> !statQ[ST_RXF]);

  a_r11_rx_off_sets_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCfg[OFF_CTRL] && !wrData[CT_RXEN]) |=> statQ[ST_TXE]);
endmodule

// File: rtl/sbuf_datapath.sv
`timescale 1ns/1ps
module sbuf_datapath
  import sbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] status,
  input  logic              sendNow,
  input  logic              rxStore,
  input  logic [DATA_W-1:0] rxByte,
  output logic              txEn,
  output logic              rxEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              txValid,
  output logic [DATA_W-1:0] txByte
);
  logic [DATA_W-1:0] cfgQ [CFG_N];
  logic [DATA_W-1:0] txdQ, rxdQ, rdQ, rdMux;
  logic              txValidQ;
  logic [DATA_W-1:0] txByteQ;

  for (genvar g = 0; g < CFG_N; g++) begin : gCfgReg
    always_ff @(posedge clk) begin
      if (!rstN)                cfgQ[g] <= '0;
      else if (strobe.wrCfg[g]) cfgQ[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txdQ     <= '0;
      rxdQ     <= '0;
      rdQ      <= '0;
      txValidQ <= 1'b0;
      txByteQ  <= '0;
    end else begin
      if (strobe.wrTxd) txdQ <= wrData;
      if (rxStore)      rxdQ <= rxByte;
      if (strobe.rdEn)  rdQ  <= rdMux;
      txValidQ <= sendNow;
      if (sendNow)      txByteQ <= txdQ;
    end
  end

  always_comb begin
    rdMux = '0;
    case (strobe.rdSel)
      OFF_TXD:  rdMux = txdQ;
      OFF_STAT: rdMux = status;
      OFF_RXD:  rdMux = rxdQ;
      default: begin
        if (strobe.rdSel < ADDR_W'(CFG_N))
          rdMux = cfgQ[strobe.rdSel[CFG_IDX_W-1:0]];
      end
    endcase
  end

  assign txEn      = cfgQ[OFF_CTRL][CT_TXEN];
  assign rxEn      = cfgQ[OFF_CTRL][CT_RXEN];
  assign busRdData = rdQ;
  assign txValid   = txValidQ;
  assign txByte    = txByteQ;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txValidQ |=> !txValidQ);

  a_r9_store_captures: assert property (@(posedge clk) disable iff (!rstN)
    rxStore |=> (rxdQ == $past(rxByte)));
endmodule

// File: rtl/sbuf_serial_ctl.sv
`timescale 1ns/1ps
module sbuf_serial_ctl
  import sbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              shifterReady,
  output logic              txValid,
  output logic [DATA_W-1:0] txByte,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte
);
  busStrobe_t        strobe;
  logic [DATA_W-1:0] status;
  logic              sendNow, rxStore, txEn, rxEn;

  sbuf_bus_decode u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  sbuf_status_unit u_status (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (busWrData),
    .txEn         (txEn),
    .rxEn         (rxEn),
    .shifterReady (shifterReady),
    .rxValid      (rxValid),
    .status       (status),
    .sendNow      (sendNow),
    .rxStore      (rxStore)
  );

  sbuf_datapath u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData),
    .status    (status),
    .sendNow   (sendNow),
    .rxStore   (rxStore),
    .rxByte    (rxByte),
    .txEn      (txEn),
    .rxEn      (rxEn),
    .busRdData (busRdData),
    .txValid   (txValid),
    .txByte    (txByte)
  );
endmodule

// File: tb/sbuf_serial_ctl_tb_top.sv
`timescale 1ns/1ps
module sbuf_serial_ctl_tb_top;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RX = 2'd2, OP_RDY = 2'd3;
  localparam int NVEC = 47;
  // {kind, addr, data, expected read, requirement number}
  localparam logic [24:0] VEC [NVEC] = '{
    {OP_RD, 3'd4, 8'h00, 8'h84, 4'd1},   // R1 reset status
    {OP_WR, 3'd0, 8'h5A, 8'h00, 4'd2},   // R2
    {OP_RD, 3'd0, 8'h00, 8'h5A, 4'd2},
    {OP_WR, 3'd1, 8'h33, 8'h00, 4'd2},
    {OP_RD, 3'd1, 8'h00, 8'h33, 4'd2},
    {OP_WR, 3'd6, 8'hFF, 8'h00, 4'd2},   // R2 unused offset
    {OP_RD, 3'd6, 8'h00, 8'h00, 4'd2},
    {OP_RD, 3'd0, 8'h00, 8'h5A, 4'd2},
    {OP_WR, 3'd2, 8'h30, 8'h00, 4'd2},
    {OP_RD, 3'd2, 8'h00, 8'h30, 4'd2},
    {OP_WR, 3'd3, 8'hC3, 8'h00, 4'd7},   // R7 tx write clears end
    {OP_RD, 3'd3, 8'h00, 8'hC3, 4'd2},
    {OP_RD, 3'd4, 8'h00, 8'h80, 4'd7},
    {OP_WR, 3'd4, 8'h00, 8'h00, 4'd3},   // R3 clear seen empty flag
    {OP_RD, 3'd4, 8'h00, 8'h00, 4'd8},   // R8 transient before send
    {OP_RD, 3'd4, 8'h00, 8'h84, 4'd8},
    {OP_RX, 3'd0, 8'h11, 8'h00, 4'd9},   // R9
    {OP_RD, 3'd4, 8'h00, 8'hC4, 4'd9},
    {OP_RD, 3'd5, 8'h00, 8'h11, 4'd9},
    {OP_RX, 3'd0, 8'h22, 8'h00, 4'd9},
    {OP_RX, 3'd0, 8'h33, 8'h00, 4'd9},   // R9 overrun, dropped
    {OP_RD, 3'd4, 8'h00, 8'hE4, 4'd9},
    {OP_RD, 3'd5, 8'h00, 8'h22, 4'd10},  // R10
    {OP_WR, 3'd4, 8'hDF, 8'h00, 4'd3},
    {OP_RD, 3'd4, 8'h00, 8'h85, 4'd4},   // R4 bit 0 loaded
    {OP_WR, 3'd4, 8'hBE, 8'h00, 4'd4},
    {OP_RX, 3'd0, 8'h55, 8'h00, 4'd9},
    {OP_WR, 3'd4, 8'hBE, 8'h00, 4'd5},   // R5 unread full flag
    {OP_RD, 3'd4, 8'h00, 8'hC4, 4'd5},
    {OP_WR, 3'd4, 8'hFF, 8'h00, 4'd3},
    {OP_RD, 3'd4, 8'h00, 8'hC5, 4'd3},   // R3 write never sets
    {OP_RD, 3'd5, 8'h00, 8'h55, 4'd10},
    {OP_RD, 3'd4, 8'h00, 8'h85, 4'd10},
    {OP_WR, 3'd2, 8'h10, 8'h00, 4'd6},   // R6 tx off
    {OP_WR, 3'd4, 8'h00, 8'h00, 4'd6},
    {OP_RD, 3'd4, 8'h00, 8'h84, 4'd6},
    {OP_WR, 3'd2, 8'h30, 8'h00, 4'd11},
    {OP_RDY, 3'd0, 8'h00, 8'h00, 4'd8},
    {OP_WR, 3'd3, 8'h77, 8'h00, 4'd7},
    {OP_WR, 3'd4, 8'h7F, 8'h00, 4'd8},
    {OP_RD, 3'd4, 8'h00, 8'h01, 4'd8},   // R8 held without ready
    {OP_WR, 3'd2, 8'h20, 8'h00, 4'd11},  // R11 rx off
    {OP_RD, 3'd4, 8'h00, 8'h81, 4'd11},
    {OP_RDY, 3'd0, 8'h01, 8'h00, 4'd11},
    {OP_RX, 3'd0, 8'h99, 8'h00, 4'd9},   // R9 ignored when rx off
    {OP_RD, 3'd4, 8'h00, 8'h81, 4'd9},
    {OP_RD, 3'd5, 8'h00, 8'h55, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       shifterReady = 1'b1;
  logic       txValid;
  logic [7:0] txByte;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = '0;

  int checks = 0, fails = 0, txCount = 0;
  logic [7:0] lastTx = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sbuf_serial_ctl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .shifterReady(shifterReady), .txValid(txValid), .txByte(txByte),
    .rxValid(rxValid), .rxByte(rxByte)
  );

  always @(posedge clk) begin
    if (rstN && txValid) begin
      txCount++;
      lastTx = txByte;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] kind, input logic [2:0] addr,
                      input logic [7:0] data, input logic [7:0] exp, input string tag);
    case (kind)
      OP_WR: begin busAddr = addr; busWrData = data; busWrEn = 1'b1; end
      OP_RD: begin busAddr = addr; busRdEn = 1'b1; end
      OP_RX: begin rxByte = data; rxValid = 1'b1; end
      default: shifterReady = data[0];
    endcase
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
    busRdEn = 1'b0;
    rxValid = 1'b0;
    if (kind == OP_RD) check(tag, busRdData, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 txValid in reset", {7'd0, txValid}, 8'h00);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      doOp(VEC[i][24:23], VEC[i][22:20], VEC[i][19:12], VEC[i][11:4],
           $sformatf("R%0d vec %0d", VEC[i][3:0], i));
    end
    check("R8 send count", 8'(txCount), 8'd1);
    check("R8 sent byte", lastTx, 8'hC3);
    check("R11 abandoned byte not sent", 8'(txCount), 8'd1);

    // mid-run reset
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 txValid low", {7'd0, txValid}, 8'h00);
    rstN = 1'b1;
    doOp(OP_RD, 3'd0, 8'h00, 8'h00, "R1 mode after reset");
    doOp(OP_RD, 3'd2, 8'h00, 8'h00, "R1 control after reset");
    doOp(OP_RD, 3'd3, 8'h00, 8'h00, "R1 txdata after reset");
    doOp(OP_WR, 3'd2, 8'h30, 8'h00, "R5");
    doOp(OP_WR, 3'd4, 8'h00, 8'h00, "R5");
    doOp(OP_RD, 3'd4, 8'h00, 8'h84, "R5 unread flags kept");
    check("R5 no send without clear", 8'(txCount), 8'd1);

    // held send released by shifterReady
    doOp(OP_WR, 3'd3, 8'h5E, 8'h00, "R7");
    doOp(OP_RD, 3'd4, 8'h00, 8'h80, "R7 end cleared by tx write");
    doOp(OP_RDY, 3'd0, 8'h00, 8'h00, "R8");
    doOp(OP_WR, 3'd4, 8'h00, 8'h00, "R8");
    repeat (3) @(negedge clk);
    doOp(OP_RD, 3'd4, 8'h00, 8'h00, "R8 byte held");
    check("R8 no send while not ready", 8'(txCount), 8'd1);
    doOp(OP_RDY, 3'd0, 8'h01, 8'h00, "R8");
    @(negedge clk);
    doOp(OP_RD, 3'd4, 8'h00, 8'h84, "R8 flags restored after send");
    check("R8 send count after release", 8'(txCount), 8'd2);
    check("R8 released byte", lastTx, 8'h5E);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule